// File: doc/BRIEF.md
# External Bus Address Strobe Generator

This block drives the address strobe pin of an 8051-style external memory bus. The strobe goes out twice per twelve-period machine cycle. Each pulse is high for two oscillator periods and starts at a fixed phase of the machine-cycle counter. During a cycle that moves data to or from external data memory, the second pulse of the machine cycle is dropped.

A software control bit can quiet the strobe to reduce radiated noise. When it is set, the pin is held low, with three exceptions:
- an external data transfer still strobes in its normal way;
- a fetch from an address above the top of internal program memory still strobes;
- when the external-access strap was captured low, every fetch is external, so the strobe always runs.

The strap is taken on the first clock edge after reset is released. In idle the pin sits high, and in power-down it sits low.

The CPU sequencer supplies the phase counter, the data-transfer flag, the fetch address and the power state. The control bit lives in a byte-wide power-control register that software writes through a write strobe.

Top module: `ale_gen`

## Requirements
- R1: While `rst_ni` is low, `ale_o` is low and the noise-quiet bit is cleared. A strobe runs after reset is released without any register write.
- R2: In run mode with the quiet bit clear and no data transfer, `ale_o` is high for the clock cycles that follow the edges where `phase_i` is 0, 1, 6 or 7. It is low after every other edge, so there is one registered cycle of latency.
- R3: If `xdata_i` is high at the edge where `phase_i` is 6, the pulse of the second slot is not produced. The slot starting at phase 0 is not affected by this.
- R4: A write with `pcon_we_i` high loads the quiet bit from `pcon_wdata_i[5]`. The other seven data bits have no effect on `ale_o`.
- R5: With the quiet bit set, the latched strap high, `xdata_i` low and `fetch_addr_i` not above `imem_top_i`, no pulse starts.
- R6: With the quiet bit set, a data transfer still strobes normally: the phase-0 pulse is produced and the phase-6 pulse is dropped.
- R7: With the quiet bit set and the latched strap high, a slot whose start sees `fetch_addr_i > imem_top_i` produces a normal pulse.
- R8: With the strap latched low, pulses follow R2 and R3 whatever the quiet bit holds.
- R9: `ea_i` is captured at the first clock edge after reset release. Later changes of `ea_i` have no effect on `ale_o`.
- R10: With `idle_i` high, `ale_o` is high from the next clock edge on. With `pd_i` high, it is low from the next edge on. `pd_i` wins over `idle_i`, and neither depends on the quiet bit.
- R11: Whether a pulse is produced is decided at the slot start edge (phase 0 or 6). Changes of `xdata_i` or `fetch_addr_i` inside the pulse neither cut it short nor start one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 4 | Oscillator phase within the machine cycle, 0 to 11 |
| xdata_i | input | 1 | Current machine cycle is an external data transfer |
| ea_i | input | 1 | External-access strap, high selects internal program memory |
| fetch_addr_i | input | 16 | Current program fetch address |
| imem_top_i | input | 16 | Highest internal program memory address |
| idle_i | input | 1 | Idle state |
| pd_i | input | 1 | Power-down state |
| pcon_we_i | input | 1 | Write strobe of the power-control register |
| pcon_wdata_i | input | 8 | Write data of the power-control register |
| ale_o | output | 1 | Address strobe pin level |

## Verification
The hardest situation to reach from the ports is the strap being re-latched. It only changes at the first edge after a reset release, so the stimulus applies a second reset with the strap low and then raises `ea_i` once the cycle has passed. With the quiet bit set at that point, the pulses must keep running. The other hard case is an input change inside a running pulse. This is reached by aligning to a slot start with an above-top address and then dropping the address one phase later. Seeded random cycles then mix transfers, power states, register writes and address crossings.

// File: rtl/ale_gen_pkg.sv
package ale_gen_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_IDLE = 2'd1,
    PWR_DOWN = 2'd2
  } pwr_e;

  typedef struct packed {
    logic start;      // edge opens a strobe slot
    logic tail;       // edge inside the slot's pulse window, after start
    logic xfer_slot;  // slot start that a data transfer drops
  } slot_t;
endpackage

// File: rtl/ale_strap_cfg.sv
module ale_strap_cfg #(
  parameter int DATA_W  = 8,
  parameter int RFI_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ea_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ea_o,
  output logic              strap_done_o,
  output logic              quiet_o
);
  logic done_q, ea_q, quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ea_q   <= 1'b1;
    end else if (!done_q) begin
      done_q <= 1'b1;
      ea_q   <= ea_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   quiet_q <= 1'b0;
    else if (we_i) quiet_q <= wdata_i[RFI_BIT];
  end

  // strap follows the pin until it has been captured
  assign ea_o         = done_q ? ea_q : ea_i;
  assign strap_done_o = done_q;
  assign quiet_o      = quiet_q;
endmodule

// File: rtl/ale_slot_dec.sv
module ale_slot_dec
  import ale_gen_pkg::*;
#(
  parameter int PHASES     = 12,
  parameter int SLOT_LEN   = 6,
  parameter int PULSE_W    = 2,
  parameter int START_OFS  = 0,
  parameter int XSKIP_SLOT = 1,
  localparam int PH_W      = $clog2(PHASES),
  localparam int NSLOT     = PHASES / SLOT_LEN
) (
  input  logic [PH_W-1:0] phase_i,
  output slot_t           slot_o
);
  logic [NSLOT-1:0]         hit;
  logic [NSLOT*PULSE_W-1:0] win;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int BASE = s * SLOT_LEN + START_OFS;
    assign hit[s] = (phase_i == PH_W'(BASE));
    for (genvar k = 0; k < PULSE_W; k++) begin : g_win
      assign win[s*PULSE_W+k] = (phase_i == PH_W'(BASE + k));
    end
  end

  assign slot_o.start     = |hit;
  assign slot_o.tail      = (|win) & ~(|hit);
  assign slot_o.xfer_slot = hit[XSKIP_SLOT];
endmodule

// File: rtl/ale_gate.sv
module ale_gate #(
  parameter int ADDR_W = 16
) (
  input  logic              quiet_i,
  input  logic              ea_i,
  input  logic              xdata_i,
  input  logic              xfer_slot_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [ADDR_W-1:0] imem_top_i,
  output logic              emit_o
);
  logic beyond, allowed, dropped;

  always_comb begin
    beyond  = fetch_addr_i > imem_top_i;
    // quiet mode only bites on internal fetches inside internal memory
    allowed = ~quiet_i | ~ea_i | xdata_i | beyond;
    dropped = xdata_i & xfer_slot_i;
    emit_o  = allowed & ~dropped;
  end
endmodule

// File: rtl/ale_gen.sv
module ale_gen
  import ale_gen_pkg::*;
#(
  parameter int PHASES     = 12,
  parameter int SLOT_LEN   = 6,
  parameter int PULSE_W    = 2,
  parameter int START_OFS  = 0,
  parameter int XSKIP_SLOT = 1,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RFI_BIT    = 5,
  localparam int PH_W      = $clog2(PHASES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              xdata_i,
  input  logic              ea_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [ADDR_W-1:0] imem_top_i,
  input  logic              idle_i,
  input  logic              pd_i,
  input  logic              pcon_we_i,
  input  logic [DATA_W-1:0] pcon_wdata_i,
  output logic              ale_o
);
  slot_t slot;
  pwr_e  pwr;
  logic  ea_lat, strap_done, quiet, emit;
  logic  armed_q, ale_q, ale_d;

  ale_strap_cfg #(.DATA_W(DATA_W), .RFI_BIT(RFI_BIT)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ea_i        (ea_i),
    .we_i        (pcon_we_i),
    .wdata_i     (pcon_wdata_i),
    .ea_o        (ea_lat),
    .strap_done_o(strap_done),
    .quiet_o     (quiet)
  );

  ale_slot_dec #(
    .PHASES(PHASES), .SLOT_LEN(SLOT_LEN), .PULSE_W(PULSE_W),
    .START_OFS(START_OFS), .XSKIP_SLOT(XSKIP_SLOT)
  ) u_dec (
    .phase_i(phase_i),
    .slot_o (slot)
  );

  ale_gate #(.ADDR_W(ADDR_W)) u_gate (
    .quiet_i     (quiet),
    .ea_i        (ea_lat),
    .xdata_i     (xdata_i),
    .xfer_slot_i (slot.xfer_slot),
    .fetch_addr_i(fetch_addr_i),
    .imem_top_i  (imem_top_i),
    .emit_o      (emit)
  );

  always_comb begin
    if (pd_i)        pwr = PWR_DOWN;
    else if (idle_i) pwr = PWR_IDLE;
    else             pwr = PWR_RUN;
  end

  always_comb begin
    unique case (pwr)
      PWR_DOWN: ale_d = 1'b0;
      PWR_IDLE: ale_d = 1'b1;
      default: begin
        if (slot.start)     ale_d = emit;
        else if (slot.tail) ale_d = armed_q;
        else                ale_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ale_q   <= 1'b0;
    end else begin
      if (slot.start) armed_q <= emit;
      ale_q <= ale_d;
    end
  end

  assign ale_o = ale_q;
endmodule

// File: rtl/ale_gen_chk.sv
module ale_gen_chk #(
  parameter int PHASES     = 12,
  parameter int SLOT_LEN   = 6,
  parameter int PULSE_W    = 2,
  parameter int START_OFS  = 0,
  parameter int XSKIP_SLOT = 1,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RFI_BIT    = 5,
  localparam int PH_W      = $clog2(PHASES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PH_W-1:0]   phase_i,
  input logic              xdata_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic [ADDR_W-1:0] imem_top_i,
  input logic              idle_i,
  input logic              pd_i,
  input logic              pcon_we_i,
  input logic [DATA_W-1:0] pcon_wdata_i,
  input logic              ale_o,
  input logic              quiet,
  input logic              ea_lat,
  input logic              strap_done
);
  int  off, slot_idx;
  logic run, start;

  always_comb begin
    off      = int'(phase_i) % SLOT_LEN;
    slot_idx = int'(phase_i) / SLOT_LEN;
    run      = !idle_i && !pd_i;
    start    = (off == START_OFS);
  end

  a_r10_pd_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !ale_o);

  a_r10_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !pd_i) |=> ale_o);

  a_r2_low_outside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (off < START_OFS || off >= START_OFS + PULSE_W)) |=> !ale_o);

  a_r3_xfer_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start && slot_idx == XSKIP_SLOT && xdata_i) |=> !ale_o);

  a_r5_quiet_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start && quiet && ea_lat && !xdata_i && fetch_addr_i <= imem_top_i)
      |=> !ale_o);

  a_r8_ext_fetch_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start && !ea_lat && !(xdata_i && slot_idx == XSKIP_SLOT)) |=> ale_o);

  a_r4_quiet_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcon_we_i |=> (quiet == $past(pcon_wdata_i[RFI_BIT])));

  a_r9_strap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done |=> $stable(ea_lat));
endmodule

bind ale_gen ale_gen_chk #(
  .PHASES(PHASES), .SLOT_LEN(SLOT_LEN), .PULSE_W(PULSE_W),
  .START_OFS(START_OFS), .XSKIP_SLOT(XSKIP_SLOT), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .RFI_BIT(RFI_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_i     (phase_i),
  .xdata_i     (xdata_i),
  .fetch_addr_i(fetch_addr_i),
  .imem_top_i  (imem_top_i),
  .idle_i      (idle_i),
  .pd_i        (pd_i),
  .pcon_we_i   (pcon_we_i),
  .pcon_wdata_i(pcon_wdata_i),
  .ale_o       (ale_o),
  .quiet       (quiet),
  .ea_lat      (ea_lat),
  .strap_done  (strap_done)
);

// File: tb/ale_gen_test.sv
module ale_gen_test;
  localparam logic [15:0] TOP = 16'h7FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ph = '0;
  logic        xdata = 1'b0, ea = 1'b1, idle = 1'b0, pd = 1'b0, we = 1'b0;
  logic [15:0] addr = 16'h0100;
  logic [7:0]  wdata = '0;
  logic        ale;

  int checks = 0, errors = 0, phase = 0;
  logic exp_ale = 0, m_armed = 0, m_started = 0, m_ea = 1, m_quiet = 0;

  always #10 clk = ~clk;

  ale_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(ph), .xdata_i(xdata), .ea_i(ea),
    .fetch_addr_i(addr), .imem_top_i(TOP), .idle_i(idle), .pd_i(pd),
    .pcon_we_i(we), .pcon_wdata_i(wdata), .ale_o(ale)
  );

  // reference rules taken from the requirements
  function automatic void model_edge();
    logic ea_eff, emit;
    int off, slot;
    ea_eff = m_started ? m_ea : ea;
    off  = phase % 6;
    slot = phase / 6;
    emit = !(xdata && slot == 1) && (!m_quiet || !ea_eff || xdata || addr > TOP);
    if (pd)             exp_ale = 1'b0;
    else if (idle)      exp_ale = 1'b1;
    else if (off == 0)  exp_ale = emit;
    else if (off == 1)  exp_ale = m_armed;
    else                exp_ale = 1'b0;
    if (off == 0) m_armed = emit;
    if (we) m_quiet = wdata[5];
    if (!m_started) begin m_ea = ea; m_started = 1'b1; end
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s phase=%0d ale actual=%b expected=%b", req, phase, act, exp);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(ale, exp_ale, req);
    phase = (phase + 1) % 12;
    ph = 4'(phase);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic align();
    while (phase != 0) step("R2");
  endtask

  task automatic do_reset(input logic ea_val);
    @(negedge clk);
    rst_n = 1'b0; ea = ea_val;
    exp_ale = 0; m_armed = 0; m_started = 0; m_quiet = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ale, 1'b0, "R1");
      phase = (phase + 1) % 12; ph = 4'(phase);
    end
    rst_n = 1'b1;
  endtask

  task automatic pcon_write(input logic [7:0] v, input string req);
    we = 1'b1; wdata = v;
    step(req);
    we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);
    run(24, "R1");                       // strobe runs without any write
    align(); run(24, "R2");

    align(); xdata = 1'b1; run(12, "R3"); xdata = 1'b0; run(12, "R3");

    pcon_write(8'h20, "R4");
    align(); run(24, "R5");
    pcon_write(8'hDF, "R4");             // bit 5 clear, others set
    align(); run(12, "R4");
    pcon_write(8'h20, "R4");
    align(); run(12, "R5");

    xdata = 1'b1; run(24, "R6"); xdata = 1'b0;
    addr = TOP + 16'd1; run(24, "R7");
    addr = TOP; run(12, "R7");

    // decision held from slot start
    align(); addr = 16'hFFFF; step("R11"); addr = 16'h0010; run(11, "R11");
    align(); step("R11"); addr = 16'hFFFF; run(5, "R11"); addr = 16'h0010; run(6, "R11");

    idle = 1'b1; run(13, "R10");
    pd = 1'b1; run(13, "R10");
    idle = 1'b0; run(7, "R10");
    pd = 1'b0; run(12, "R10");

    do_reset(1'b0);
    step("R9");
    ea = 1'b1;
    pcon_write(8'h20, "R8");
    align(); run(24, "R8");
    xdata = 1'b1; run(12, "R8"); xdata = 1'b0;

    do_reset(1'b1);
    run(3, "R9");
    ea = 1'b0;
    pcon_write(8'h20, "R9");
    align(); run(24, "R9");

    for (int i = 0; i < 4000; i++) begin
      xdata = ($urandom % 4) == 0;
      idle  = ($urandom % 16) == 0;
      pd    = ($urandom % 24) == 0;
      we    = ($urandom % 12) == 0;
      wdata = 8'($urandom);
      addr  = ($urandom % 2) ? TOP + 16'($urandom % 64) : 16'($urandom % 256);
      if (($urandom % 500) == 0) ea = ~ea;
      step("R11");
    end
    we = 1'b0; idle = 1'b0; pd = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule